// File: doc/BRIEF.md
# Endpoint Descriptor List Walker

This block walks one transfer list of a USB host controller, for example the control list or the bulk list. The list is a chain of endpoint descriptors held in system memory. Each descriptor is four 32-bit words and is aligned to 16 bytes. The walker reads the four words one at a time through a single-outstanding read port.

For each descriptor it decides whether the endpoint has queued transfer descriptors. The endpoint is passed over when its skip flag or its halted flag is set, or when its head and tail pointers are equal. Otherwise the walker offers the head transfer-descriptor address and the endpoint's parameter word to a downstream executor over a valid/ready handshake. It then waits for the executor to finish and writes the returned head pointer back into the descriptor. After that it moves on along the next-descriptor pointer.

Software loads a current-descriptor pointer and a list head pointer, raises the list-filled flag and sets the enable bit. The walker runs only while both the enable bit and the list-filled flag are set. When it reaches the end of the list it returns to the list head. The list-filled flag drops once a whole pass, counted from one end of the list to the next, has found no work.

Top module: `ed_list_walker`

## Requirements
- R1: After reset, memReq, memWr and tdValid are low, listFilled is 0 and curPtr is 0.
- R2: A new descriptor fetch starts only while listEnable is 1 and listFilled is 1. With either of them at 0, memReq stays low.
- R3: A descriptor is read as four single-cycle requests to curPtr+0, +4, +8 and +12, in that order. A new request is issued only after memRdValid has returned the previous word.
- R4: When word 0 bit 14 (skip) is set, nothing is dispatched and the next fetch targets the descriptor named by word 3 bits 31:4.
- R5: When word 2 bit 0 (halted) is set, nothing is dispatched and the walker advances to the next descriptor.
- R6: When word 2 bits 31:4 (head) equal word 1 bits 31:4 (tail), nothing is dispatched and the walker advances.
- R7: Otherwise tdValid rises with tdAddr = head bits 31:4 followed by four zero bits and tdEpInfo = word 0. Both hold steady until tdReady is seen.
- R8: After the handshake, the cycle after exDone carries a single memWr to curPtr+8. The written data is exHead bits 31:4, then the old word 2 bits 3:2, then exHead bits 1:0 (toggle carry at bit 1, halted at bit 0).
- R9: After a descriptor is finished, curPtr takes word 3 bits 31:4. A zero next pointer instead reloads curPtr from listHead.
- R10: At a zero next pointer, listFilled is cleared if no descriptor was dispatched since the previous list end or since reset. Otherwise it stays set and walking continues from the head.
- R11: A fillSet pulse sets listFilled from the next cycle. A curLoad pulse while the walker is idle loads curPtr from curInit, with the low four bits forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| listEnable | input | 1 | Software enable for this list |
| fillSet | input | 1 | Pulse: software marks the list as filled |
| curLoad | input | 1 | Pulse: load current-descriptor pointer |
| curInit | input | 32 | Value loaded by curLoad |
| listHead | input | 32 | Address of the first descriptor of the list |
| listFilled | output | 1 | List-filled flag |
| curPtr | output | 32 | Current-descriptor pointer |
| memReq | output | 1 | Single-cycle word read request |
| memAddr | output | 32 | Read address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| memWr | output | 1 | Single-cycle word write strobe |
| memWrAddr | output | 32 | Write address |
| memWrData | output | 32 | Write data |
| tdValid | output | 1 | Transfer descriptor offered to the executor |
| tdReady | input | 1 | Executor accepts the offer |
| tdAddr | output | 32 | Head transfer-descriptor address |
| tdEpInfo | output | 32 | Endpoint parameter word (word 0) |
| exDone | input | 1 | Executor finished, exHead valid |
| exHead | input | 32 | Updated head word returned by the executor |

## Verification
The hardest case to reach from the ports is the list-filled flag that survives one pass and drops on the next. It needs a pass that dispatches work, followed by a pass in which the same descriptors have become empty. The stimulus builds a four-descriptor list in which only one entry has work, and its executor returns a head pointer equal to that entry's tail. The write-back therefore empties the list by itself. The fetch log then shows a second full pass from the head, with listFilled still set at its start and cleared at its end. A later run loads the current pointer into the middle of the list, so that a partial pass is what ends the walk.

// File: rtl/ed_walk_pkg.sv
package ed_walk_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_DECIDE, S_DISP, S_EXEC, S_WBACK, S_ADV
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCur;
    logic clrIdx;
    logic capWord;
    logic incIdx;
    logic noteWork;
    logic capExec;
    logic advance;
  } walkStrobe_t;

  // descriptor word roles
  localparam int W_INFO = 0;
  localparam int W_TAIL = 1;
  localparam int W_HEAD = 2;
  localparam int W_NEXT = 3;
  localparam int SKIP_BIT = 14;
  localparam int HALT_BIT = 0;

endpackage

// File: rtl/ed_walk_dp.sv
module ed_walk_dp
  import ed_walk_pkg::*;
#(
  parameter int DW    = 32,
  parameter int WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       stb,
  input  logic              fillSet,
  input  logic [DW-1:0]     curInit,
  input  logic [DW-1:0]     listHead,
  input  logic [DW-1:0]     rdData,
  input  logic [DW-1:0]     exHead,
  output logic [DW-1:0]     curPtr,
  output logic [DW-1:0]     fetchAddr,
  output logic [DW-1:0]     wrAddr,
  output logic [DW-1:0]     wrData,
  output logic [DW-1:0]     headAddr,
  output logic [DW-1:0]     epInfo,
  output logic              lastWord,
  output logic              passOver,
  output logic              listFilled
);
  localparam int IW    = $clog2(WORDS);
  localparam int ALIGN = IW + 2;

  logic [DW-1:0] edWord [WORDS];
  logic [IW-1:0] idx;
  logic [DW-1:0] exReg;
  logic          passWork;
  logic          atEnd;
  logic          skipFlag, haltFlag, emptyFlag;

  // one capture register per descriptor word
  for (genvar g = 0; g < WORDS; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN) edWord[g] <= '0;
      else if (stb.capWord && idx == IW'(g)) edWord[g] <= rdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) idx <= '0;
    else if (stb.clrIdx) idx <= '0;
    else if (stb.incIdx) idx <= idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) exReg <= '0;
    else if (stb.capExec) exReg <= exHead;
  end

  assign atEnd = (edWord[W_NEXT][DW-1:ALIGN] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) curPtr <= '0;
    else if (stb.advance)
      curPtr <= atEnd ? {listHead[DW-1:ALIGN], {ALIGN{1'b0}}}
                      : {edWord[W_NEXT][DW-1:ALIGN], {ALIGN{1'b0}}};
    else if (stb.loadCur)
      curPtr <= {curInit[DW-1:ALIGN], {ALIGN{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) passWork <= 1'b0;
    else if (stb.advance && atEnd) passWork <= 1'b0;
    else if (stb.noteWork) passWork <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) listFilled <= 1'b0;
    else if (fillSet) listFilled <= 1'b1;
    else if (stb.advance && atEnd && !passWork) listFilled <= 1'b0;
  end

  assign skipFlag  = edWord[W_INFO][SKIP_BIT];
  assign haltFlag  = edWord[W_HEAD][HALT_BIT];
  assign emptyFlag = edWord[W_HEAD][DW-1:ALIGN] == edWord[W_TAIL][DW-1:ALIGN];
  assign passOver  = skipFlag | haltFlag | emptyFlag;
  assign lastWord  = (idx == IW'(WORDS - 1));

  assign fetchAddr = {curPtr[DW-1:ALIGN], idx, 2'b00};
  assign wrAddr    = {curPtr[DW-1:ALIGN], IW'(W_HEAD), 2'b00};
  assign wrData    = {exReg[DW-1:ALIGN], edWord[W_HEAD][ALIGN-1:2], exReg[1:0]};
  assign headAddr  = {edWord[W_HEAD][DW-1:ALIGN], {ALIGN{1'b0}}};
  assign epInfo    = edWord[W_INFO];

endmodule

// File: rtl/ed_walk_ctrl.sv
module ed_walk_ctrl
  import ed_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        listEnable,
  input  logic        listFilled,
  input  logic        curLoad,
  input  logic        rdValid,
  input  logic        lastWord,
  input  logic        passOver,
  input  logic        tdReady,
  input  logic        exDone,
  output walkStrobe_t stb,
  output logic        memReq,
  output logic        memWr,
  output logic        tdValid
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    memReq    = 1'b0;
    memWr     = 1'b0;
    tdValid   = 1'b0;
    unique case (state)
      S_IDLE: begin
        stb.clrIdx  = 1'b1;
        stb.loadCur = curLoad;
        if (listEnable && listFilled && !curLoad) nextState = S_REQ;
      end
      S_REQ: begin
        memReq    = 1'b1;
        nextState = S_WAIT;
      end
      S_WAIT: begin
        if (rdValid) begin
          stb.capWord = 1'b1;
          if (lastWord) nextState = S_DECIDE;
          else begin
            stb.incIdx = 1'b1;
            nextState  = S_REQ;
          end
        end
      end
      S_DECIDE: begin
        if (passOver) nextState = S_ADV;
        else begin
          stb.noteWork = 1'b1;
          nextState    = S_DISP;
        end
      end
      S_DISP: begin
        tdValid = 1'b1;
        if (tdReady) nextState = S_EXEC;
      end
      S_EXEC: begin
        if (exDone) begin
          stb.capExec = 1'b1;
          nextState   = S_WBACK;
        end
      end
      S_WBACK: begin
        memWr     = 1'b1;
        nextState = S_ADV;
      end
      S_ADV: begin
        stb.advance = 1'b1;
        nextState   = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/ed_list_walker.sv
module ed_list_walker
  import ed_walk_pkg::*;
#(
  parameter int DW    = 32,
  parameter int WORDS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          listEnable,
  input  logic          fillSet,
  input  logic          curLoad,
  input  logic [DW-1:0] curInit,
  input  logic [DW-1:0] listHead,
  output logic          listFilled,
  output logic [DW-1:0] curPtr,
  output logic          memReq,
  output logic [DW-1:0] memAddr,
  input  logic          memRdValid,
  input  logic [DW-1:0] memRdData,
  output logic          memWr,
  output logic [DW-1:0] memWrAddr,
  output logic [DW-1:0] memWrData,
  output logic          tdValid,
  input  logic          tdReady,
  output logic [DW-1:0] tdAddr,
  output logic [DW-1:0] tdEpInfo,
  input  logic          exDone,
  input  logic [DW-1:0] exHead
);
  walkStrobe_t stb;
  logic        lastWord;
  logic        passOver;

  ed_walk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .listEnable (listEnable),
    .listFilled (listFilled),
    .curLoad    (curLoad),
    .rdValid    (memRdValid),
    .lastWord   (lastWord),
    .passOver   (passOver),
    .tdReady    (tdReady),
    .exDone     (exDone),
    .stb        (stb),
    .memReq     (memReq),
    .memWr      (memWr),
    .tdValid    (tdValid)
  );

  ed_walk_dp #(.DW(DW), .WORDS(WORDS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .fillSet    (fillSet),
    .curInit    (curInit),
    .listHead   (listHead),
    .rdData     (memRdData),
    .exHead     (exHead),
    .curPtr     (curPtr),
    .fetchAddr  (memAddr),
    .wrAddr     (memWrAddr),
    .wrData     (memWrData),
    .headAddr   (tdAddr),
    .epInfo     (tdEpInfo),
    .lastWord   (lastWord),
    .passOver   (passOver),
    .listFilled (listFilled)
  );

endmodule

// File: rtl/ed_walk_checker.sv
module ed_walk_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          listEnable,
  input logic          listFilled,
  input logic          fillSet,
  input logic          memReq,
  input logic [DW-1:0] memAddr,
  input logic          memWr,
  input logic [DW-1:0] memWrAddr,
  input logic          tdValid,
  input logic          tdReady,
  input logic [DW-1:0] tdAddr,
  input logic          exDone
);
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R3
  AST_FETCH_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAddr[3:2] == 2'd0) |-> $past(listEnable && listFilled)); // R2
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (tdValid && !tdReady) |=> (tdValid && $stable(tdAddr))); // R7
  AST_OFFER_NO_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    tdValid |-> !memReq && !memWr); // R7
  AST_WB_WORD2: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> memWrAddr[3:0] == 4'h8); // R8
  AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(exDone)); // R8
  AST_FILL_SET: assert property (@(posedge clk) disable iff (!rstN)
    fillSet |=> listFilled); // R11
endmodule

bind ed_list_walker ed_walk_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .listEnable (listEnable),
  .listFilled (listFilled),
  .fillSet    (fillSet),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memWr      (memWr),
  .memWrAddr  (memWrAddr),
  .tdValid    (tdValid),
  .tdReady    (tdReady),
  .tdAddr     (tdAddr),
  .exDone     (exDone)
);

// File: tb/tb_ed_list_walker.sv
`timescale 1ns/1ps
module tb_ed_list_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        listEnable = 1'b0, fillSet = 1'b0, curLoad = 1'b0;
  logic [31:0] curInit = '0, listHead = '0;
  logic        listFilled;
  logic [31:0] curPtr;
  logic        memReq, memWr, tdValid;
  logic [31:0] memAddr, memWrAddr, memWrData, tdAddr, tdEpInfo;
  logic        memRdValid = 1'b0, tdReady = 1'b0, exDone = 1'b0;
  logic [31:0] memRdData = '0, exHead = '0;

  always #4 clk = ~clk;

  ed_list_walker dut (.*);

  int errors = 0, checks = 0;
  logic [31:0] mem [64];
  logic [31:0] reqLog [64];
  logic        fillLog [64];
  int reqCount = 0, overlapErr = 0, dispCount = 0, wrCount = 0;
  logic [31:0] dispAddr, dispInfo, lastWrAddr, lastWrData;
  logic [31:0] exReturn = 32'h0000_0182;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // memory model: latency 2, one request outstanding
  initial begin
    bit pend = 0;
    int cnt = 0;
    logic [31:0] a = '0;
    forever begin
      @(negedge clk);
      if (pend && cnt == 0) begin
        memRdValid = 1'b1; memRdData = mem[a[7:2]]; pend = 0;
      end else begin
        memRdValid = 1'b0;
        if (pend) cnt--;
      end
      if (memReq) begin
        if (pend) overlapErr++;
        if (reqCount < 64) begin
          reqLog[reqCount] = memAddr; fillLog[reqCount] = listFilled;
        end
        reqCount++;
        pend = 1; a = memAddr; cnt = 1;
      end
      if (memWr) begin
        mem[memWrAddr[7:2]] = memWrData;
        wrCount++; lastWrAddr = memWrAddr; lastWrData = memWrData;
      end
    end
  end

  // executor model
  initial begin
    int ph = 0, cnt = 0;
    forever begin
      @(negedge clk);
      case (ph)
        0: if (tdValid) begin ph = 1; cnt = 2; end
        1: begin
             cnt--;
             if (cnt == 0) begin
               tdReady = 1'b1; dispAddr = tdAddr; dispInfo = tdEpInfo; ph = 2;
             end
           end
        2: begin tdReady = 1'b0; dispCount++; cnt = 3; ph = 3; end
        3: begin
             cnt--;
             if (cnt == 0) begin exDone = 1'b1; exHead = exReturn; ph = 4; end
           end
        default: begin exDone = 1'b0; ph = 0; end
      endcase
    end
  end

  task automatic pulseFill();
    @(negedge clk); fillSet = 1'b1; @(negedge clk); fillSet = 1'b0;
  endtask

  task automatic loadCur(input logic [31:0] v);
    @(negedge clk); curInit = v; curLoad = 1'b1; @(negedge clk); curLoad = 1'b0;
  endtask

  task automatic waitDrained();
    int n = 0;
    while (listFilled && n < 5000) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
  endtask

  task automatic buildList();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    // A @0x10: skip set, work pending
    mem[4] = 32'h0000_4005; mem[5] = 32'h100; mem[6] = 32'h120; mem[7] = 32'h20;
    // B @0x20: halted, work pending
    mem[8] = 32'h0040_0006; mem[9] = 32'h140; mem[10] = 32'h161; mem[11] = 32'h30;
    // C @0x30: runnable, head bits 3:2 = 2'b10
    mem[12] = 32'h0200_0387; mem[13] = 32'h180; mem[14] = 32'h1A8; mem[15] = 32'h40;
    // D @0x40: empty, end of list
    mem[16] = 32'h0008_0008; mem[17] = 32'h1C0; mem[18] = 32'h1C0; mem[19] = 32'h0;
  endtask

  task automatic testReset();
    chk(memReq == 0 && memWr == 0 && tdValid == 0, "R1 strobes idle", {29'd0, memReq, memWr, tdValid}, 0);
    chk(listFilled == 0, "R1 listFilled", {31'd0, listFilled}, 0);
    chk(curPtr == 0, "R1 curPtr", curPtr, 0);
  endtask

  task automatic testGate();
    listEnable = 1'b1;
    repeat (20) @(negedge clk);
    chk(reqCount == 0, "R2 no fetch while not filled", reqCount, 0);
    listEnable = 1'b0;
    loadCur(32'h0000_001B);
    chk(curPtr == 32'h10, "R11 curLoad aligned", curPtr, 32'h10);
    pulseFill();
    chk(listFilled == 1, "R11 fillSet", {31'd0, listFilled}, 1);
    repeat (20) @(negedge clk);
    chk(reqCount == 0, "R2 no fetch while disabled", reqCount, 0);
  endtask

  task automatic testWalk();
    listEnable = 1'b1;
    waitDrained();
    chk(reqLog[0] == 32'h10 && reqLog[1] == 32'h14 && reqLog[2] == 32'h18 && reqLog[3] == 32'h1C,
        "R3 word order", reqLog[3], 32'h1C);
    chk(overlapErr == 0, "R3 single outstanding", overlapErr, 0);
    chk(reqLog[4] == 32'h20, "R4 skip advances", reqLog[4], 32'h20);
    chk(reqLog[8] == 32'h30, "R5 halted advances", reqLog[8], 32'h30);
    chk(dispCount == 1, "R4 R5 R6 only one dispatch", dispCount, 1);
    chk(dispAddr == 32'h1A0, "R7 tdAddr", dispAddr, 32'h1A0);
    chk(dispInfo == 32'h0200_0387, "R7 tdEpInfo", dispInfo, 32'h0200_0387);
    chk(wrCount == 1 && lastWrAddr == 32'h38, "R8 write address", lastWrAddr, 32'h38);
    chk(lastWrData == 32'h18A, "R8 write data", lastWrData, 32'h18A);
    chk(reqLog[12] == 32'h40, "R9 follow next", reqLog[12], 32'h40);
    chk(reqLog[16] == 32'h10, "R6 R9 wrap to head", reqLog[16], 32'h10);
    chk(fillLog[16] == 1'b1, "R10 filled kept after work", {31'd0, fillLog[16]}, 1);
    chk(reqCount == 32, "R10 second pass then stop", reqCount, 32);
    chk(listFilled == 0, "R10 cleared after empty pass", {31'd0, listFilled}, 0);
    chk(curPtr == 32'h10, "R9 reload from head", curPtr, 32'h10);
  endtask

  task automatic testMidStart();
    reqCount = 0;
    loadCur(32'h30);
    chk(curPtr == 32'h30, "R11 curLoad mid list", curPtr, 32'h30);
    pulseFill();
    waitDrained();
    chk(reqCount == 8 && reqLog[0] == 32'h30 && reqLog[4] == 32'h40,
        "R10 partial pass ends walk", reqCount, 8);
    chk(dispCount == 1, "R6 emptied entry not dispatched", dispCount, 1);
    chk(listFilled == 0 && curPtr == 32'h10, "R9 R10 end state", curPtr, 32'h10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    buildList();
    listHead = 32'h10;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGate();
    testWalk();
    testMidStart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule